// File: doc/BRIEF.md
# Multi-Mode Counter/Delay Logic Cell

This cell pairs a small logic stage with an 8-bit down-counter. The logic stage is either a 3-input lookup table with a configurable truth table, or a D flip-flop whose third input is an active-low control. A configuration bit chooses whether that control sets or clears the flop. The counter core runs in one of five modes: delayed edge propagation, free-running counting, one-shot pulse, frequency detection and edge detection. A routing bit places the logic stage either in front of the counter or behind it. In front, it drives the counter input. Behind, it takes the counter output on its input 0.

All configuration arrives on static inputs that stand in for non-volatile settings. They must only be changed while `por_n` is low. The exception is the logic stage's truth table and control polarity.

Everything runs on one system clock. The counter advances only on a tick. The tick source is one of:
- every clock;
- one of two external tick enables;
- the chain input, which carries the previous cell's counter output and so builds longer counts.

An optional two-flop synchronizer sits on the counter input. When it is enabled, the input reaches the counter two cycles later and the counter powers up at zero. When it is bypassed, the counter powers up holding the count data. The output level during and after reset is selectable: low, high, or the counter input's current level.

The counter is controlled by a two-state machine:
- `ST_IDLE`: no count in progress.
- `ST_RUN`: counting down toward zero.

Its transitions are:
- *start* (`ST_IDLE` to `ST_RUN`): a selected edge arrives in delay, one-shot or frequency mode.
- *expire* (`ST_RUN` to `ST_IDLE`): a tick arrives while the count is zero.
- *cancel* (`ST_RUN` to `ST_IDLE`): in delay mode, the input returns to the output level.
- *restart* (`ST_RUN` to `ST_RUN`): in frequency mode, a new edge reloads the count.
- Counter mode stays in `ST_RUN`.
- Edge mode stays in `ST_IDLE`.

Top module: `mfcell_top`

## Requirements
- R1: In LUT mode (`cfg_dff`=0), `logic_out` equals `cfg_tt[{lut2,lut1,lut0}]` combinationally. Here `lut2` and `lut1` are `lin[2]` and `lin[1]`. `lut0` is `lin[0]` when `cfg_route`=0, and `cnt_out` when `cfg_route`=1.
- R2: In flop mode (`cfg_dff`=1), input 0 is data, input 1 is the flop clock and input 2 is the active-low control. A rising level on input 1 (seen from one clock to the next) loads the data at that clock edge. While the control is low, the flop takes `cfg_ctl_set` at every clock, and this overrides the flop clock. Reset clears the flop.
- R3: With `cfg_route`=0, the counter input is `logic_out` and `cell_out`=`cnt_out`. With `cfg_route`=1, the counter input is `cnt_in`, `lin[0]` is ignored and `cell_out`=`logic_out`.
- R4: Delay mode (`cfg_mode`=0) works as follows:
  - A selected edge makes `cnt_out` take the new input level after `cfg_data`+1 ticks. With ticking every clock, that is `cfg_data`+1 clocks after the clock that sees the edge.
  - An edge that is not selected passes at the next clock.
  - `cfg_edge` bit 0 selects rising edges and bit 1 selects falling edges.
- R5: In delay mode, if the input returns to the output level before expiry, the delay is cancelled and `cnt_out` does not change.
- R6: Counter mode (`cfg_mode`=1) behaves as follows:
  - The count goes from `cfg_data` down to zero and reloads.
  - `cnt_out` is high for one clock every `cfg_data`+1 ticks.
  - A selected input edge reloads `cfg_data`.
  - Between reloads the count only steps down by one.
- R7: One-shot mode (`cfg_mode`=2) responds to a selected edge from idle by making `cnt_out` high for exactly `cfg_data`+1 ticks. Edges during the pulse are ignored.
- R8: Frequency mode (`cfg_mode`=3) updates `cnt_out` on each selected edge. The output goes to 1 if that edge comes within `cfg_data`+1 ticks of the previous one, and to 0 otherwise. The level is held between edges.
- R9: Edge mode (`cfg_mode`=4) makes `cnt_out` high for one clock after each selected edge.
- R10: `cfg_src` selects the tick: 0 is every clock, 1 is `tick_a`, 2 is `tick_b` and 3 is `chain_in`. Without a tick the count does not move.
- R11: During and after reset, `cnt_out` takes the level set by `cfg_init`: 0 is low, 1 is high and 2 follows the counter input. When `cnt_out` starts low and the input is high, a delay starts as if a rising edge had arrived.
- R12: With `cfg_sync`=1, the counter input passes through two flops, which adds two clocks of latency, and `count_val` resets to 0. With `cfg_sync`=0, `count_val` resets to `cfg_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset, synchronous |
| cfg_mode | input | 3 | Counter mode: 0 delay, 1 counter, 2 one-shot, 3 frequency, 4 edge |
| cfg_edge | input | 2 | Edge select: bit 0 rising, bit 1 falling |
| cfg_data | input | W | Count data |
| cfg_src | input | 2 | Tick source select |
| cfg_route | input | 1 | 0: logic stage before counter, 1: after counter |
| cfg_init | input | 2 | Power-up output: 0 low, 1 high, 2 follow input |
| cfg_sync | input | 1 | Enable two-flop input synchronizer |
| cfg_dff | input | 1 | Logic stage as flop (1) or LUT (0) |
| cfg_ctl_set | input | 1 | Flop control acts as set (1) or reset (0) |
| cfg_tt | input | 8 | LUT truth table |
| lin | input | 3 | Logic stage inputs |
| cnt_in | input | 1 | Counter input when the counter leads |
| tick_a | input | 1 | External tick enable A |
| tick_b | input | 1 | External tick enable B |
| chain_in | input | 1 | Previous cell's counter output used as tick |
| logic_out | output | 1 | Logic stage output |
| cnt_out | output | 1 | Counter output, also used for chaining |
| cell_out | output | 1 | Cell output selected by routing |
| count_val | output | W | Current count |

## Verification
Some properties are checked on every cycle:
- The count only steps down by one or reloads the count data.
- The count holds when the chain tick is low.
- A running one-shot stays high while the count is non-zero.
- A delayed rising output only appears once the count has reached zero.
- A low flop control forces the configured level.

Other behaviour can only be shown by the bench's scenarios:
- The exact expiry clocks of delay, one-shot and counter mode across a sweep of count values.
- The threshold of the frequency detector across a sweep of edge gaps.
- The full truth-table sweep.
- Delay cancellation and the power-up levels.
- The extra two clocks added by the synchronizer.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
    typedef enum logic [2:0] {
        MD_DELAY   = 3'd0,
        MD_COUNT   = 3'd1,
        MD_ONESHOT = 3'd2,
        MD_FREQ    = 3'd3,
        MD_EDGE    = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        PU_LOW    = 2'd0,
        PU_HIGH   = 2'd1,
        PU_FOLLOW = 2'd2
    } pwrup_e;

    typedef enum logic [1:0] {
        SRC_CLK    = 2'd0,
        SRC_TICK_A = 2'd1,
        SRC_TICK_B = 2'd2,
        SRC_CHAIN  = 2'd3
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cst_e;
endpackage

// File: rtl/mfc_logic.sv
module mfc_logic #(
    parameter int N_IN = 3,
    localparam int TT_W = 1 << N_IN
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            cfg_dff,
    input  logic            cfg_ctl_set,
    input  logic [TT_W-1:0] cfg_tt,
    input  logic [N_IN-1:0] lut_in,
    output logic            q
);
    localparam int D_IDX   = 0;
    localparam int CK_IDX  = 1;
    localparam int CTL_IDX = 2;

    logic ck_prev;
    logic ff_q;

    always_ff @(posedge clk) begin
        if (!por_n) begin
            ck_prev <= 1'b0;
            ff_q    <= 1'b0;
        end else begin
            ck_prev <= lut_in[CK_IDX];
            if (!lut_in[CTL_IDX]) begin
                ff_q <= cfg_ctl_set;
            end else if (lut_in[CK_IDX] && !ck_prev) begin
                ff_q <= lut_in[D_IDX];
            end
        end
    end

    assign q = cfg_dff ? ff_q : cfg_tt[lut_in];
endmodule

// File: rtl/mfc_insync.sv
module mfc_insync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic sync_on,
    input  logic init_lvl,
    input  logic raw,
    output logic din,
    output logic rise,
    output logic fall
);
    logic [DEPTH-1:0] stg;
    logic [DEPTH-1:0] stg_d;
    logic             prev;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stg_d[g] = raw;
        end else begin : g_rest
            assign stg_d[g] = stg[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            stg  <= {DEPTH{init_lvl}};
            prev <= init_lvl;
        end else begin
            stg  <= stg_d;
            prev <= din;
        end
    end

    assign din  = sync_on ? stg[DEPTH-1] : raw;
    assign rise = din & ~prev;
    assign fall = ~din & prev;
endmodule

// File: rtl/mfc_counter.sv
module mfc_counter
    import mfc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  mode_e        mode,
    input  logic [1:0]   edge_sel,
    input  logic [W-1:0] data,
    input  logic         init_lvl,
    input  logic         sync_on,
    input  logic         tick,
    input  logic         din,
    input  logic         rise,
    input  logic         fall,
    output logic         q,
    output logic [W-1:0] cnt
);
    cst_e         st, st_n;
    logic [W-1:0] cnt_n;
    logic         q_n;
    logic         hit;
    logic         at_zero;

    assign hit     = (rise & edge_sel[0]) | (fall & edge_sel[1]);
    assign at_zero = (cnt == '0);

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        q_n   = q;
        case (mode)
            MD_DELAY: begin
                unique case (st)
                    ST_IDLE: begin
                        if (hit) begin
                            st_n  = ST_RUN;
                            cnt_n = data;
                        end else if (rise | fall) begin
                            q_n = din;
                        end
                    end
                    ST_RUN: begin
                        if (din == q) begin
                            st_n = ST_IDLE;
                        end else if (tick) begin
                            if (at_zero) begin
                                q_n  = din;
                                st_n = ST_IDLE;
                            end else begin
                                cnt_n = cnt - 1'b1;
                            end
                        end
                    end
                endcase
            end
            MD_COUNT: begin
                q_n  = 1'b0;
                st_n = ST_RUN;
                if (hit) begin
                    cnt_n = data;
                end else if (tick) begin
                    if (at_zero) begin
                        cnt_n = data;
                        q_n   = 1'b1;
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                end
            end
            MD_ONESHOT: begin
                unique case (st)
                    ST_IDLE: begin
                        if (hit) begin
                            q_n   = 1'b1;
                            cnt_n = data;
                            st_n  = ST_RUN;
                        end
                    end
                    ST_RUN: begin
                        if (tick) begin
                            if (at_zero) begin
                                q_n  = 1'b0;
                                st_n = ST_IDLE;
                            end else begin
                                cnt_n = cnt - 1'b1;
                            end
                        end
                    end
                endcase
            end
            MD_FREQ: begin
                if (hit) begin
                    q_n   = (st == ST_RUN);
                    cnt_n = data;
                    st_n  = ST_RUN;
                end else if (st == ST_RUN && tick) begin
                    if (at_zero) begin
                        st_n = ST_IDLE;
                    end else begin
                        cnt_n = cnt - 1'b1;
                    end
                end
            end
            MD_EDGE: begin
                q_n  = hit;
                st_n = ST_IDLE;
            end
            default: begin
                q_n  = 1'b0;
                st_n = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!por_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            q   <= init_lvl;
            cnt <= sync_on ? '0 : data;
        end else begin
            q   <= q_n;
            cnt <= cnt_n;
        end
    end
endmodule

// File: rtl/mfcell_top.sv
module mfcell_top
    import mfc_pkg::*;
#(
    parameter int W          = 8,
    parameter int N_IN       = 3,
    parameter int SYNC_DEPTH = 2,
    localparam int TT_W      = 1 << N_IN
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic [2:0]      cfg_mode,
    input  logic [1:0]      cfg_edge,
    input  logic [W-1:0]    cfg_data,
    input  logic [1:0]      cfg_src,
    input  logic            cfg_route,
    input  logic [1:0]      cfg_init,
    input  logic            cfg_sync,
    input  logic            cfg_dff,
    input  logic            cfg_ctl_set,
    input  logic [TT_W-1:0] cfg_tt,
    input  logic [N_IN-1:0] lin,
    input  logic            cnt_in,
    input  logic            tick_a,
    input  logic            tick_b,
    input  logic            chain_in,
    output logic            logic_out,
    output logic            cnt_out,
    output logic            cell_out,
    output logic [W-1:0]    count_val
);
    logic [N_IN-1:0] lut_in;
    logic            raw_in;
    logic            init_lvl;
    logic            tick;
    logic            din, rise, fall;

    assign lut_in = {lin[N_IN-1:1], cfg_route ? cnt_out : lin[0]};
    assign raw_in = cfg_route ? cnt_in : logic_out;

    always_comb begin
        unique case (pwrup_e'(cfg_init))
            PU_HIGH:   init_lvl = 1'b1;
            PU_FOLLOW: init_lvl = raw_in;
            default:   init_lvl = 1'b0;
        endcase
    end

    always_comb begin
        unique case (src_e'(cfg_src))
            SRC_TICK_A: tick = tick_a;
            SRC_TICK_B: tick = tick_b;
            SRC_CHAIN:  tick = chain_in;
            default:    tick = 1'b1;
        endcase
    end

    mfc_logic #(.N_IN(N_IN)) u_logic (
        .clk        (clk),
        .por_n      (por_n),
        .cfg_dff    (cfg_dff),
        .cfg_ctl_set(cfg_ctl_set),
        .cfg_tt     (cfg_tt),
        .lut_in     (lut_in),
        .q          (logic_out)
    );

    mfc_insync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .por_n   (por_n),
        .sync_on (cfg_sync),
        .init_lvl(init_lvl),
        .raw     (raw_in),
        .din     (din),
        .rise    (rise),
        .fall    (fall)
    );

    mfc_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .por_n   (por_n),
        .mode    (mode_e'(cfg_mode)),
        .edge_sel(cfg_edge),
        .data    (cfg_data),
        .init_lvl(init_lvl),
        .sync_on (cfg_sync),
        .tick    (tick),
        .din     (din),
        .rise    (rise),
        .fall    (fall),
        .q       (cnt_out),
        .cnt     (count_val)
    );

    assign cell_out = cfg_route ? logic_out : cnt_out;
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         por_n,
    input logic [2:0]   cfg_mode,
    input logic [1:0]   cfg_edge,
    input logic [W-1:0] cfg_data,
    input logic [1:0]   cfg_src,
    input logic         cfg_dff,
    input logic         cfg_ctl_set,
    input logic [2:0]   lin,
    input logic         chain_in,
    input logic         logic_out,
    input logic         cnt_out,
    input logic [W-1:0] count_val
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(count_val) |-> (count_val == $past(count_val) - 1'b1) || (count_val == cfg_data)); // R6

    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_src == 2'd3 && !chain_in) |=> (count_val == $past(count_val)) || (count_val == cfg_data)); // R10

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_mode == 3'd2 && cnt_out && count_val != '0) |=> cnt_out); // R7

    AST_DELAY_AT_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_mode == 3'd0 && cfg_edge[0] && $rose(cnt_out)) |-> ($past(count_val) == '0)); // R4

    AST_FLOP_CONTROL: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_dff && !lin[2]) |=> (logic_out == $past(cfg_ctl_set))); // R2
endmodule

bind mfcell_top mfc_checker #(.W(W)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .cfg_mode   (cfg_mode),
    .cfg_edge   (cfg_edge),
    .cfg_data   (cfg_data),
    .cfg_src    (cfg_src),
    .cfg_dff    (cfg_dff),
    .cfg_ctl_set(cfg_ctl_set),
    .lin        (lin),
    .chain_in   (chain_in),
    .logic_out  (logic_out),
    .cnt_out    (cnt_out),
    .count_val  (count_val)
);

// File: tb/mfcell_top_tb_top.sv
`timescale 1ns/1ps
module mfcell_top_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [2:0] cfg_mode = '0;
    logic [1:0] cfg_edge = 2'd1;
    logic [7:0] cfg_data = '0;
    logic [1:0] cfg_src = '0;
    logic       cfg_route = 1'b1;
    logic [1:0] cfg_init = '0;
    logic       cfg_sync = 1'b0;
    logic       cfg_dff = 1'b0;
    logic       cfg_ctl_set = 1'b0;
    logic [7:0] cfg_tt = 8'hAA;
    logic [2:0] lin = '0;
    logic       cnt_in = 1'b0;
    logic       tick_a = 1'b0;
    logic       tick_b = 1'b0;
    logic       chain_in = 1'b0;
    logic       logic_out, cnt_out, cell_out;
    logic [7:0] count_val;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    mfcell_top dut_i (
        .clk(clk), .por_n(por_n), .cfg_mode(cfg_mode), .cfg_edge(cfg_edge),
        .cfg_data(cfg_data), .cfg_src(cfg_src), .cfg_route(cfg_route),
        .cfg_init(cfg_init), .cfg_sync(cfg_sync), .cfg_dff(cfg_dff),
        .cfg_ctl_set(cfg_ctl_set), .cfg_tt(cfg_tt), .lin(lin), .cnt_in(cnt_in),
        .tick_a(tick_a), .tick_b(tick_b), .chain_in(chain_in),
        .logic_out(logic_out), .cnt_out(cnt_out), .cell_out(cell_out),
        .count_val(count_val)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic [2:0] md, input logic [1:0] ed, input logic [7:0] dt,
                         input logic [1:0] sr, input logic rt, input logic [1:0] ini,
                         input logic sy, input logic cin);
        @(negedge clk);
        por_n = 1'b0;
        cfg_mode = md; cfg_edge = ed; cfg_data = dt; cfg_src = sr; cfg_route = rt;
        cfg_init = ini; cfg_sync = sy; cnt_in = cin;
        cfg_dff = 1'b0; cfg_ctl_set = 1'b0; cfg_tt = 8'hAA; lin = '0;
        tick_a = 1'b0; tick_b = 1'b0; chain_in = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R11 reset state: low power-up level
        setup(3'd0, 2'd1, 8'd3, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R11 reset low", cnt_out, 0);
        // R12 count value after reset without synchronizer
        chk("R12 reset count no sync", count_val, 3);

        // R1 full truth-table sweep
        setup(3'd4, 2'd0, 8'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
        for (int tt = 0; tt < 256; tt++) begin
            for (int v = 0; v < 8; v++) begin
                cfg_tt = tt[7:0];
                lin = v[2:0];
                #1;
                chk("R1 lut", logic_out, (tt >> v) & 1);
            end
        end

        // R4 delay sweep, rising selected
        for (int n = 0; n <= 16; n++) begin
            int nn;
            nn = (n == 16) ? 255 : n;
            setup(3'd0, 2'd1, nn[7:0], 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
            cnt_in = 1'b1;
            for (int i = 0; i <= nn + 2; i++) begin
                @(negedge clk);
                chk("R4 delay rise", cnt_out, (i >= nn + 1) ? 1 : 0);
            end
            cnt_in = 1'b0;
            @(negedge clk);
            chk("R4 unselected fall passes", cnt_out, 0);
        end

        // R4 both edges delayed
        setup(3'd0, 2'd3, 8'd2, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
        cnt_in = 1'b1;
        for (int i = 0; i <= 3; i++) begin
            @(negedge clk);
            chk("R4 both rise", cnt_out, (i >= 3) ? 1 : 0);
        end
        cnt_in = 1'b0;
        for (int i = 0; i <= 3; i++) begin
            @(negedge clk);
            chk("R4 both fall", cnt_out, (i >= 3) ? 0 : 1);
        end

        // R5 cancel
        setup(3'd0, 2'd1, 8'd10, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
        cnt_in = 1'b1;
        repeat (3) @(negedge clk);
        cnt_in = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            chk("R5 cancelled delay", cnt_out, 0);
        end

        // R6 counter mode period sweep
        for (int n = 0; n <= 6; n++) begin
            setup(3'd1, 2'd1, n[7:0], 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
            for (int k = 1; k <= 3 * (n + 1); k++) begin
                @(negedge clk);
                chk("R6 count period", cnt_out, (k % (n + 1) == 0) ? 1 : 0);
            end
        end
        // R6 edge reloads the count
        setup(3'd1, 2'd1, 8'd4, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
        repeat (7) @(negedge clk);
        cnt_in = 1'b1;
        for (int i = 0; i <= 5; i++) begin
            @(negedge clk);
            chk("R6 reload on edge", cnt_out, (i == 5) ? 1 : 0);
        end

        // R7 one-shot width sweep
        for (int n = 0; n <= 10; n++) begin
            setup(3'd2, 2'd1, n[7:0], 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
            cnt_in = 1'b1;
            for (int i = 0; i <= n + 2; i++) begin
                @(negedge clk);
                chk("R7 one-shot width", cnt_out, (i <= n) ? 1 : 0);
            end
        end
        // R7 retrigger ignored
        setup(3'd2, 2'd1, 8'd8, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
        cnt_in = 1'b1;
        for (int i = 0; i <= 11; i++) begin
            @(negedge clk);
            chk("R7 retrigger ignored", cnt_out, (i <= 8) ? 1 : 0);
            if (i == 2) cnt_in = 1'b0;
            if (i == 4) cnt_in = 1'b1;
        end

        // R8 frequency threshold sweep, count data 5
        for (int g = 2; g <= 9; g++) begin
            setup(3'd3, 2'd1, 8'd5, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
            cnt_in = 1'b1;
            for (int j = 0; j < g; j++) begin
                @(negedge clk);
                if (j == 0) chk("R8 first edge", cnt_out, 0);
                if (j == 0) cnt_in = 1'b0;
                if (j == g - 1) cnt_in = 1'b1;
            end
            @(negedge clk);
            chk("R8 frequency detect", cnt_out, (g <= 6) ? 1 : 0);
        end

        // R9 edge mode
        setup(3'd4, 2'd3, 8'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
        cnt_in = 1'b1;
        @(negedge clk); chk("R9 rise pulse", cnt_out, 1);
        @(negedge clk); chk("R9 pulse one clock", cnt_out, 0);
        cnt_in = 1'b0;
        @(negedge clk); chk("R9 fall pulse", cnt_out, 1);
        @(negedge clk); chk("R9 pulse one clock", cnt_out, 0);
        setup(3'd4, 2'd2, 8'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
        cnt_in = 1'b1;
        @(negedge clk); chk("R9 rise not selected", cnt_out, 0);
        cnt_in = 1'b0;
        @(negedge clk); chk("R9 fall selected", cnt_out, 1);

        // R3 routing
        setup(3'd4, 2'd3, 8'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
        lin = 3'b001;
        @(negedge clk); chk("R3 lut feeds counter", cell_out, 1);
        setup(3'd4, 2'd1, 8'd0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0);
        lin = 3'b001;
        @(negedge clk); chk("R3 lin0 ignored when counter leads", cell_out, 0);
        cnt_in = 1'b1;
        @(negedge clk); chk("R3 counter feeds lut", cell_out, 1);

        // R10 tick sources
        setup(3'd0, 2'd1, 8'd3, 2'd1, 1'b1, 2'd0, 1'b0, 1'b0);
        cnt_in = 1'b1;
        repeat (20) @(negedge clk);
        chk("R10 no tick holds", cnt_out, 0);
        chk("R10 no tick count", count_val, 3);
        for (int t = 1; t <= 4; t++) begin
            tick_a = 1'b1;
            @(negedge clk);
            chk("R10 tick_a", cnt_out, (t >= 4) ? 1 : 0);
            tick_a = 1'b0;
            @(negedge clk);
        end
        setup(3'd0, 2'd1, 8'd0, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0);
        cnt_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 tick_b idle", cnt_out, 0);
        tick_b = 1'b1;
        @(negedge clk);
        chk("R10 tick_b", cnt_out, 1);
        setup(3'd0, 2'd1, 8'd4, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0);
        cnt_in = 1'b1;
        chain_in = 1'b1;
        for (int i = 0; i <= 5; i++) begin
            @(negedge clk);
            chk("R10 chain tick", cnt_out, (i >= 5) ? 1 : 0);
        end

        // R11 power-up levels
        setup(3'd0, 2'd1, 8'd3, 2'd0, 1'b1, 2'd1, 1'b0, 1'b1);
        @(negedge clk); chk("R11 init high", cnt_out, 1);
        setup(3'd0, 2'd1, 8'd3, 2'd0, 1'b1, 2'd2, 1'b0, 1'b1);
        @(negedge clk); chk("R11 follow high", cnt_out, 1);
        setup(3'd0, 2'd1, 8'd3, 2'd0, 1'b1, 2'd2, 1'b0, 1'b0);
        @(negedge clk); chk("R11 follow low", cnt_out, 0);
        setup(3'd0, 2'd1, 8'd2, 2'd0, 1'b1, 2'd0, 1'b0, 1'b1);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk("R11 low start delays", cnt_out, (k >= 4) ? 1 : 0);
        end

        // R12 synchronizer
        setup(3'd0, 2'd1, 8'd3, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0);
        chk("R12 reset count with sync", count_val, 0);
        cnt_in = 1'b1;
        for (int i = 0; i <= 7; i++) begin
            @(negedge clk);
            chk("R12 sync latency", cnt_out, (i >= 6) ? 1 : 0);
        end

        // R2 flop mode, lin = {ctl, ck, d}
        setup(3'd4, 2'd0, 8'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0);
        cfg_dff = 1'b1;
        lin = 3'b101; @(negedge clk); chk("R2 no clock edge", logic_out, 0);
        lin = 3'b111; @(negedge clk); chk("R2 capture 1", logic_out, 1);
        lin = 3'b110; @(negedge clk); chk("R2 hold without edge", logic_out, 1);
        lin = 3'b100; @(negedge clk); chk("R2 hold on fall", logic_out, 1);
        lin = 3'b110; @(negedge clk); chk("R2 capture 0", logic_out, 0);
        cfg_ctl_set = 1'b1;
        lin = 3'b010; @(negedge clk); chk("R2 control sets", logic_out, 1);
        lin = 3'b000; @(negedge clk); chk("R2 control held", logic_out, 1);
        lin = 3'b010; @(negedge clk); chk("R2 control beats clock", logic_out, 1);
        cfg_ctl_set = 1'b0;
        @(negedge clk); chk("R2 control resets", logic_out, 0);
        lin = 3'b100; @(negedge clk); chk("R2 release keeps", logic_out, 0);

        finish_run();
    end
endmodule